// File: doc/BRIEF.md
# Block-Granular Secure/Non-secure SRAM Alias Guard

This block sits between a bus interconnect and an on-chip SRAM. The SRAM is split into blocks of equal size, and each block has one configuration bit that says whether it is Secure or Non-secure. The same physical memory is decoded at two address windows. One address bit above the memory range selects the window. A window bit of 0 selects the Secure alias and 1 selects the Non-secure alias. A block is visible only through the window that matches its bit. Any access through the other window lands in a hole. It is answered with a two-cycle bus error, and it never reaches the memory. The same rule applies whether the request comes from a processor or from a DMA engine.

Every transfer carries a security attribute from its master. A Non-secure master can never use the Secure window. A Secure master can use either window, but only for blocks whose bit matches that window. The per-block bits are held in 32-bit registers on a small configuration port. Only Secure requests can change them. Non-secure requests see zeros when they read and get an error when they write.

Top module: `blkmem_sec_guard`

## Requirements
- R1: After reset all configuration bits are 0, so every block is Secure. The bus reports bus_ready=1 and bus_err=0.
- R2: The decode is fixed. bus_addr[ADDR_W-1] is the window bit (1 = Non-secure window). bus_addr[ADDR_W-2:BLK_W] is the block index. Block n is controlled by bit n%32 of configuration register n/32. A configuration bit of 1 marks the block Non-secure.
- R3: A transfer passes when the window bit equals the block's configuration bit and the transfer is not (bus_nonsec=1 with window bit 0). A Secure master (bus_nonsec=0) may therefore access a Non-secure block through the Non-secure window.
- R4: A transfer with bus_nonsec=1 to the Secure window always faults.
- R5: A faulted transfer gets a two-cycle response. In the first data-phase cycle bus_ready=0 and bus_err=1. In the second, bus_ready=1 and bus_err=1.
- R6: A faulted write never asserts mem_we and leaves the memory unchanged. A faulted read returns bus_rdata=0 in both response cycles.
- R7: A passing read returns the memory word at index bus_addr[ADDR_W-2:2] in the cycle after the address phase. A passing write asserts mem_we with bus_wdata in that cycle, at the same word index. bus_err stays 0.
- R8: A Secure configuration write (cfg_nonsec=0) updates register cfg_addr at the clock edge. A Secure configuration read returns the register value on cfg_rdata one cycle later.
- R9: A Non-secure configuration write leaves the register unchanged and raises cfg_err for exactly one cycle. A Non-secure configuration read returns 0 without cfg_err.
- R10: The block size is a parameter. By default it is 256 bytes, 512 bytes for memories above 256 KB, and 1 KB above 512 KB. Every byte offset inside a block is governed by that block's single bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Valid transfer in the address phase |
| bus_addr | input | ADDR_W | Byte address: window bit on top, then the memory offset |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_nonsec | input | 1 | Master security attribute, 1 = Non-secure |
| bus_wdata | input | DATA_W | Write data, valid in the data phase |
| bus_rdata | output | DATA_W | Read data, zero unless a passing read is in its data phase |
| bus_ready | output | 1 | Transfer completion / address-phase acceptance |
| bus_err | output | 1 | Error response |
| mem_re | output | 1 | SRAM read strobe, synchronous read |
| mem_raddr | output | WORD_W | SRAM read word index |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after mem_re |
| mem_we | output | 1 | SRAM write strobe |
| mem_waddr | output | WORD_W | SRAM write word index |
| mem_wdata | output | DATA_W | SRAM write data |
| cfg_sel | input | 1 | Configuration access request |
| cfg_write | input | 1 | 1 = configuration write |
| cfg_nonsec | input | 1 | Configuration requester attribute, 1 = Non-secure |
| cfg_addr | input | CFG_AW | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, one cycle after the request |
| cfg_err | output | 1 | Configuration error pulse for a Non-secure write |

## Verification
The bench sweeps every block under three configuration patterns. For each block it tries both windows, both master attributes and both directions, and it places the offset at different points inside the block. This catches a swapped window polarity or a block index taken from the wrong address bits: the wrong block's bit would be used, and a legal access would fault, or a hole would pass. Each faulted write is followed by a check of the memory word. A guard that blocked the error but still let the strobe through would show a corrupted word. Each faulted read is checked for zero data, so a design that leaked the SRAM output would show non-zero data. The configuration port is tested with Non-secure writes of hostile values followed by Secure read-back. A design that failed to gate the write enable on the attribute would therefore quietly reopen blocks.

// File: rtl/blkmem_pkg.sv
package blkmem_pkg;

   typedef enum logic [1:0] {
      PH_OK   = 2'd0,
      PH_ERR1 = 2'd1,
      PH_ERR2 = 2'd2
   } phase_e;

   function automatic int dflt_blk_bytes(input int mem_bytes);
      if (mem_bytes > 512 * 1024)      return 1024;
      else if (mem_bytes > 256 * 1024) return 512;
      else                             return 256;
   endfunction

endpackage

// File: rtl/blkmem_cfg_regs.sv
module blkmem_cfg_regs #(
   parameter int NREG   = 2,
   parameter int CFG_AW = 1,
   localparam int NBLK  = NREG * 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sel,
   input  logic              cfg_write,
   input  logic              cfg_nonsec,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              cfg_err,
   output logic [NBLK-1:0]   blk_ns
);

   logic [31:0] regs [NREG];
   logic        in_range;
   logic        sec_wr;

   assign in_range = (int'(cfg_addr) < NREG);
   assign sec_wr   = cfg_sel && cfg_write && !cfg_nonsec && in_range;

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[k] <= '0;
         else if (sec_wr && (cfg_addr == CFG_AW'(k)))
            regs[k] <= cfg_wdata;
      end
      assign blk_ns[k*32 +: 32] = regs[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_rdata <= '0;
         cfg_err   <= 1'b0;
      end else begin
         cfg_err   <= cfg_sel && cfg_write && cfg_nonsec;
         cfg_rdata <= (cfg_sel && !cfg_write && !cfg_nonsec && in_range)
                      ? regs[cfg_addr] : '0;
      end
   end

endmodule

// File: rtl/blkmem_alias_chk.sv
module blkmem_alias_chk #(
   parameter int ADDR_W = 15,
   parameter int BLK_W  = 8,
   localparam int NBLK  = 1 << (ADDR_W - 1 - BLK_W),
   localparam int IDX_W = ADDR_W - 1 - BLK_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              nonsec,
   input  logic [NBLK-1:0]   blk_ns,
   output logic              pass
);

   logic             win_ns;
   logic [IDX_W-1:0] idx;
   logic             blk_bit;
   logic [BLK_W-1:0] unused_ofs;

   assign win_ns     = addr[ADDR_W-1];
   assign idx        = addr[ADDR_W-2:BLK_W];
   assign unused_ofs = addr[BLK_W-1:0];
   assign blk_bit    = blk_ns[idx];

   always_comb begin
      pass = (win_ns == blk_bit);
      if (nonsec && !win_ns)
         pass = 1'b0;
   end

endmodule

// File: rtl/blkmem_resp_fsm.sv
module blkmem_resp_fsm
   import blkmem_pkg::*;
#(
   parameter int WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              pass,
   input  logic              is_write,
   input  logic [WORD_W-1:0] word_idx,
   output logic              ready,
   output logic              err,
   output logic              dp_wr,
   output logic              dp_rd,
   output logic [WORD_W-1:0] dp_waddr
);

   phase_e ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_OK;
         dp_wr    <= 1'b0;
         dp_rd    <= 1'b0;
         dp_waddr <= '0;
      end else begin
         dp_wr <= accept && pass && is_write;
         dp_rd <= accept && pass && !is_write;
         if (accept)
            dp_waddr <= word_idx;
         case (ph)
            PH_ERR1: ph <= PH_ERR2;
            default: ph <= (accept && !pass) ? PH_ERR1 : PH_OK;
         endcase
      end
   end

   assign ready = (ph != PH_ERR1);
   assign err   = (ph != PH_OK);

endmodule

// File: rtl/blkmem_sec_guard.sv
module blkmem_sec_guard
   import blkmem_pkg::*;
#(
   parameter int MEM_BYTES  = 16384,
   parameter int BLK_BYTES  = dflt_blk_bytes(MEM_BYTES),
   parameter int DATA_W     = 32,
   localparam int OFS_W     = $clog2(MEM_BYTES),
   localparam int ADDR_W    = OFS_W + 1,
   localparam int BLK_W     = $clog2(BLK_BYTES),
   localparam int BYTE_W    = $clog2(DATA_W / 8),
   localparam int WORD_W    = OFS_W - BYTE_W,
   localparam int NBLK      = MEM_BYTES / BLK_BYTES,
   localparam int NREG      = (NBLK + 31) / 32,
   localparam int CFG_AW    = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_write,
   input  logic              bus_nonsec,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   output logic              bus_err,
   output logic              mem_re,
   output logic [WORD_W-1:0] mem_raddr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_waddr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              cfg_sel,
   input  logic              cfg_write,
   input  logic              cfg_nonsec,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic              cfg_err
);

   if ((MEM_BYTES & (MEM_BYTES - 1)) != 0) begin : g_bad_mem
      $error("MEM_BYTES must be a power of two");
   end
   if ((BLK_BYTES & (BLK_BYTES - 1)) != 0 || BLK_BYTES < DATA_W / 8) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two of at least one word");
   end
   if (NBLK % 32 != 0) begin : g_bad_nblk
      $error("block count must be a multiple of 32");
   end
   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_dw
      $error("DATA_W must be 32 or 64");
   end

   logic [NREG*32-1:0] blk_ns;
   logic               pass;
   logic               accept;
   logic               dp_rd;
   logic [WORD_W-1:0]  word_idx;
   logic [BYTE_W-1:0]  unused_lsb;

   assign word_idx   = bus_addr[OFS_W-1:BYTE_W];
   assign unused_lsb = bus_addr[BYTE_W-1:0];
   assign accept     = bus_sel && bus_ready;

   blkmem_cfg_regs #(
      .NREG   (NREG),
      .CFG_AW (CFG_AW)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_sel    (cfg_sel),
      .cfg_write  (cfg_write),
      .cfg_nonsec (cfg_nonsec),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .cfg_err    (cfg_err),
      .blk_ns     (blk_ns)
   );

   blkmem_alias_chk #(
      .ADDR_W (ADDR_W),
      .BLK_W  (BLK_W)
   ) u_alias (
      .addr   (bus_addr),
      .nonsec (bus_nonsec),
      .blk_ns (blk_ns[NBLK-1:0]),
      .pass   (pass)
   );

   blkmem_resp_fsm #(
      .WORD_W (WORD_W)
   ) u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .pass     (pass),
      .is_write (bus_write),
      .word_idx (word_idx),
      .ready    (bus_ready),
      .err      (bus_err),
      .dp_wr    (mem_we),
      .dp_rd    (dp_rd),
      .dp_waddr (mem_waddr)
   );

   assign mem_re    = accept && pass && !bus_write;
   assign mem_raddr = word_idx;
   assign mem_wdata = bus_wdata;
   assign bus_rdata = dp_rd ? mem_rdata : '0;

endmodule

// File: rtl/blkmem_guard_chk.sv
module blkmem_guard_chk #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 32,
   parameter int WORD_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_write,
   input logic              bus_nonsec,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_ready,
   input logic              bus_err,
   input logic              mem_we,
   input logic [WORD_W-1:0] mem_waddr,
   input logic              cfg_sel,
   input logic              cfg_write,
   input logic              cfg_nonsec,
   input logic              cfg_err
);

   // R5
   err_first_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_err) |-> !bus_ready);

   // R5
   err_second_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && !bus_ready) |=> (bus_err && bus_ready));

   // R1
   ready_only_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ready |-> bus_err);

   // R6
   no_write_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> !mem_we);

   // R6
   zero_rdata_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_rdata == '0));

   // R4
   ns_secure_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_ready && bus_nonsec && !bus_addr[ADDR_W-1]) |=> (bus_err && !bus_ready));

   // R7
   write_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(bus_sel && bus_ready && bus_write)
                  && mem_waddr == $past(bus_addr[ADDR_W-2:ADDR_W-1-WORD_W])));

   // R9
   cfg_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cfg_sel && cfg_write && cfg_nonsec));

endmodule

bind blkmem_sec_guard blkmem_guard_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .WORD_W (WORD_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_addr   (bus_addr),
   .bus_write  (bus_write),
   .bus_nonsec (bus_nonsec),
   .bus_rdata  (bus_rdata),
   .bus_ready  (bus_ready),
   .bus_err    (bus_err),
   .mem_we     (mem_we),
   .mem_waddr  (mem_waddr),
   .cfg_sel    (cfg_sel),
   .cfg_write  (cfg_write),
   .cfg_nonsec (cfg_nonsec),
   .cfg_err    (cfg_err)
);

// File: tb/sim_blkmem_sec_guard.sv
`timescale 1ns/1ps
module sim_blkmem_sec_guard;

   localparam int MB     = 4096;
   localparam int BB     = 64;
   localparam int AW     = 13;
   localparam int WW     = 10;
   localparam int NB     = MB / BB;
   localparam int NWORDS = MB / 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_write = 1'b0;
   logic          bus_nonsec = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          bus_ready, bus_err;
   logic          mem_re, mem_we;
   logic [WW-1:0] mem_raddr, mem_waddr;
   logic [31:0]   mem_rdata, mem_wdata;
   logic          cfg_sel = 1'b0, cfg_write = 1'b0, cfg_nonsec = 1'b0;
   logic [0:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [31:0]   cfg_rdata;
   logic          cfg_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [31:0] mem    [NWORDS];
   logic [31:0] shadow [NWORDS];
   logic [31:0] cfgv   [2];

   always #2.5 clk = ~clk;

   blkmem_sec_guard #(.MEM_BYTES(MB), .BLK_BYTES(BB)) u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_write(bus_write),
      .bus_nonsec(bus_nonsec), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .bus_err(bus_err),
      .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .cfg_sel(cfg_sel), .cfg_write(cfg_write), .cfg_nonsec(cfg_nonsec),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .cfg_err(cfg_err)
   );

   always @(posedge clk) begin
      if (mem_we) mem[mem_waddr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_raddr];
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_op(input bit wr, input bit ns, input int idx, input logic [31:0] wd,
                         output logic [31:0] rd, output logic er);
      @(negedge clk);
      cfg_sel = 1'b1; cfg_write = wr; cfg_nonsec = ns;
      cfg_addr = idx[0:0]; cfg_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      rd = cfg_rdata; er = cfg_err;
      cfg_sel = 1'b0;
   endtask

   task automatic xfer(input int p, input int b, input bit win, input bit ns, input bit wr);
      int          ofs;
      int          widx;
      bit          blk_bit;
      bit          exp_pass;
      logic [31:0] wd;
      ofs      = ((b * 5 + p * 3) % (BB / 4)) * 4;
      widx     = (b * BB + ofs) / 4;
      blk_bit  = cfgv[b / 32][b % 32];
      exp_pass = (win == blk_bit) && !(ns && !win);
      wd       = {4'(p), 8'(b), 3'(win), 1'(ns), 16'(widx * 7 + 3)};
      @(negedge clk);
      bus_sel = 1'b1; bus_write = wr; bus_nonsec = ns;
      bus_addr = {win, 6'(b), 6'(ofs)};
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wdata = wd;
      if (exp_pass) begin
         // R3 R7: a legal transfer completes with no error
         check("R3 pass ready/err", {30'd0, bus_ready, bus_err}, 32'h2);
         if (!wr) check("R7 read data", bus_rdata, shadow[widx]);
         @(negedge clk);
         if (wr) begin
            shadow[widx] = wd;
            check("R7 write stored", mem[widx], wd);
         end
      end else begin
         // R4 R5 R6: hole gives two-cycle error, zero data
         check(ns && !win ? "R4 R5 err cycle 1" : "R5 err cycle 1",
               {bus_rdata[29:0], bus_ready, bus_err}, 32'h1);
         @(negedge clk);
         check("R5 R6 err cycle 2", {bus_rdata[29:0], bus_ready, bus_err}, 32'h3);
         @(negedge clk);
         check("R1 back to ok", {30'd0, bus_ready, bus_err}, 32'h2);
         if (wr) check("R6 faulted write no change", mem[widx], shadow[widx]);
      end
   endtask

   initial begin
      logic [31:0] rd;
      logic        er;
      for (int i = 0; i < NWORDS; i++) begin
         mem[i]    = 32'h5A00_0000 ^ (i * 32'h0001_0101);
         shadow[i] = 32'h5A00_0000 ^ (i * 32'h0001_0101);
      end
      repeat (3) @(negedge clk);
      // R1: reset state of bus response
      check("R1 reset ready/err", {30'd0, bus_ready, bus_err}, 32'h2);
      rst_n = 1'b1;
      for (int r = 0; r < 2; r++) begin
         cfg_op(1'b0, 1'b0, r, '0, rd, er);
         check("R1 cfg reset zero", rd, 32'h0);
      end
      for (int p = 0; p < 3; p++) begin
         cfgv[0] = (p == 0) ? 32'h0 : (p == 1) ? 32'hA5A5_0F0F : 32'hFFFF_FFFF;
         cfgv[1] = (p == 0) ? 32'h0 : (p == 1) ? 32'h1234_8001 : 32'hFFFF_FFFF;
         for (int r = 0; r < 2; r++) begin
            cfg_op(1'b1, 1'b0, r, cfgv[r], rd, er);
            check("R8 secure write no err", {31'd0, er}, 32'h0);
            cfg_op(1'b1, 1'b1, r, ~cfgv[r] ^ 32'h0BAD_0000, rd, er);
            check("R9 ns write err", {31'd0, er}, 32'h1);
            cfg_op(1'b0, 1'b0, r, '0, rd, er);
            check("R8 R9 secure readback", rd, cfgv[r]);
            cfg_op(1'b0, 1'b1, r, '0, rd, er);
            check("R9 ns read zero", {rd[30:0], er}, 32'h0);
         end
         // R2 R10: every block, both windows, both attributes, both directions
         for (int b = 0; b < NB; b++)
            for (int w = 0; w < 2; w++)
               for (int s = 0; s < 2; s++)
                  for (int d = 0; d < 2; d++)
                     xfer(p, b, w[0], s[0], d[0]);
      end
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule